// File: doc/BRIEF.md
# Address-Latched RAM Writer and Bank Mapper

This block serves a 6502-class processor that drives a 13-bit cartridge address but offers no write strobe at the cartridge edge. The cartridge window is 4K. Address bit 11 splits it into a lower and an upper 2K slot. Each slot shows one of four 2K internal banks. Banks 0, 1 and 2 are RAM, and bank 3 is ROM. The block drives a plain memory port into the bank storage. Reads pass the storage byte straight back as the read data.

Because the cartridge never sees a write strobe, RAM is written through the address. A read in the trigger page copies the low eight address bits into a hold register and arms a pending write. The byte then lands in RAM on the fifth distinct bus access after it was latched. That access also picks the target location. A read of the control address does something different: it loads the hold register into the configuration. The configuration holds three things: the slot mapping, the write-enable bit and the ROM power bit.

Top module: `ramwr_bank_mapper`

## Requirements
- R1: After reset the lower slot shows bank 2 and the upper slot shows bank 3 (ROM). `cfgWriteEn` and `romPower` are 0 and no write is pending.
- R2: `memAddr` is `{bank, busAddr[10:0]}`, where bank is the bank mapped to the slot that `busAddr[11]` selects (1 = upper). `rdData` equals `memRdData`.
- R3: A bus access with `busAddr[11:8] == 0` loads `busAddr[7:0]` into the hold register and arms a pending write. This happens unless write enable is set and a write is already pending.
- R4: An access to `busAddr == 13'h1FF8` clears the pending write and applies the hold register. Bit 1 becomes `cfgWriteEn`, bit 0 becomes `romPower`, and bits 4:2 choose the {lower, upper} banks: 0→{2,3}, 1→{0,3}, 2→{2,0}, 3→{0,2}, 4→{2,3}, 5→{1,3}, 6→{2,1}, 7→{1,2}. The configuration changes at no other time.
- R5: With write enable set and a write pending, the fifth distinct access after the latching access asserts `memWrEn` for that cycle. It writes the hold byte on `memWrData` to that access's mapped `memAddr`.
- R6: An access to the same address as the previous bus access is not counted as distinct.
- R7: A commit clears the pending write, so a sixth access writes nothing. A pending write that has gone more than five distinct accesses without a commit is cancelled. Two consecutive cycles never both assert `memWrEn`.
- R8: While write enable is set and a write is pending, a trigger-page access does not reload the hold register. If it is the fifth distinct access, it commits the older byte into the lower slot.
- R9: A commit aimed at the upper slot while that slot maps bank 3 writes nothing, so ROM is never modified.
- R10: While `cfgWriteEn` is 0, `memWrEn` stays 0.
- R11: `memWrEn` is asserted only in cycles where `busEn` is high. Cycles with `busEn` low are not bus accesses and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Current cycle is a bus access |
| busAddr | input | 13 | Cartridge address from the CPU |
| rdData | output | 8 | Read data returned to the CPU |
| cfgWriteEn | output | 1 | Write-enable bit of the configuration |
| romPower | output | 1 | ROM power bit of the configuration |
| memAddr | output | 13 | Bank storage address {bank, offset} |
| memWrEn | output | 1 | Bank storage write strobe |
| memWrData | output | 8 | Bank storage write byte |
| memRdData | input | 8 | Bank storage read byte |

## Verification
The bench builds the block with its default parameters: a 13-bit address, 8-bit data, a commit distance of five and the control address 13'h1FF8. These values allow every mapping case to be exercised by direct address sequences. The sequences include repeated addresses that must not advance the distance count, and a fifth access that falls in the trigger page. They also include a fifth access into ROM, and accesses beyond the fifth. A behavioural 8K storage model sits on the memory port and is preloaded with a known ROM pattern, so committed bytes and blocked writes both show up in later reads.

// File: rtl/rwmap_pkg.sv
package rwmap_pkg;

  typedef struct packed {
    logic latch;     // load hold register, arm pending write
    logic applyCfg;  // take hold register as configuration
    logic commit;    // store hold register at current address
  } ctlStrobes_t;

  localparam int BANK_W      = 2;
  localparam logic [BANK_W-1:0] ROM_BANK = 2'd3;
  localparam int CFG_PWR_BIT = 0;
  localparam int CFG_WE_BIT  = 1;
  localparam int CFG_MAP_LSB = 2;
  localparam int CFG_MAP_W   = 3;

  // Returns {lowerBank, upperBank} for a mapping selector
  function automatic logic [2*BANK_W-1:0] slotPair(input logic [CFG_MAP_W-1:0] sel);
    logic [2*BANK_W-1:0] pair;
    case (sel)
      3'd0: pair = {2'd2, 2'd3};
      3'd1: pair = {2'd0, 2'd3};
      3'd2: pair = {2'd2, 2'd0};
      3'd3: pair = {2'd0, 2'd2};
      3'd4: pair = {2'd2, 2'd3};
      3'd5: pair = {2'd1, 2'd3};
      3'd6: pair = {2'd2, 2'd1};
      default: pair = {2'd1, 2'd2};
    endcase
    return pair;
  endfunction

endpackage

// File: rtl/rwmap_ctrl.sv
module rwmap_ctrl
  import rwmap_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 8,
  parameter int COMMIT_DIST = 5,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 13'h1FF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEnCfg,
  output ctlStrobes_t       strb
);

  localparam int SLOT_BIT = ADDR_W - 2;
  localparam int SAT      = COMMIT_DIST + 1;
  localparam int CNT_W    = $clog2(SAT + 1);

  logic [ADDR_W-1:0] prevAddr;
  logic              prevValid;
  logic [CNT_W-1:0]  distCnt;
  logic              pending;

  logic             isDistinct;
  logic [CNT_W-1:0] cntNext;
  logic             pendLive;
  logic             inTrigPage;
  logic             atCtl;

  always_comb begin
    isDistinct = !prevValid || (busAddr != prevAddr);
    if (isDistinct && (distCnt != CNT_W'(SAT)))
      cntNext = distCnt + CNT_W'(1);
    else
      cntNext = distCnt;
    // a write left pending beyond the commit distance is dropped
    pendLive   = pending && (cntNext <= CNT_W'(COMMIT_DIST));
    inTrigPage = (busAddr[SLOT_BIT:PAGE_W] == '0);
    atCtl      = (busAddr == CTL_ADDR);

    strb.latch    = busEn && inTrigPage && (!wrEnCfg || !pendLive);
    strb.applyCfg = busEn && !strb.latch && atCtl;
    strb.commit   = busEn && !strb.latch && !atCtl && wrEnCfg && pendLive
                    && (cntNext == CNT_W'(COMMIT_DIST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr  <= '0;
      prevValid <= 1'b0;
      distCnt   <= '0;
      pending   <= 1'b0;
    end else if (busEn) begin
      prevAddr  <= busAddr;
      prevValid <= 1'b1;
      if (strb.latch) begin
        distCnt <= '0;
        pending <= 1'b1;
      end else begin
        distCnt <= cntNext;
        pending <= pendLive && !strb.applyCfg && !strb.commit;
      end
    end
  end

endmodule

// File: rtl/rwmap_dp.sv
module rwmap_dp
  import rwmap_pkg::*;
#(
  parameter int OFF_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [OFF_W:0]           slotAddr,
  input  ctlStrobes_t              strb,
  input  logic [DATA_W-1:0]        memRdData,
  output logic [BANK_W+OFF_W-1:0]  memAddr,
  output logic                     memWrEn,
  output logic [DATA_W-1:0]        memWrData,
  output logic [DATA_W-1:0]        rdData,
  output logic                     cfgWriteEn,
  output logic                     romPower
);

  logic [DATA_W-1:0] holdReg;
  logic [BANK_W-1:0] lowerBank;
  logic [BANK_W-1:0] upperBank;
  logic [BANK_W-1:0] slotBank;
  logic              upperSel;
  logic [2*BANK_W-1:0] newPair;

  assign newPair = slotPair(holdReg[CFG_MAP_LSB +: CFG_MAP_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      {lowerBank, upperBank} <= slotPair('0);
      cfgWriteEn <= 1'b0;
      romPower   <= 1'b0;
    end else begin
      if (strb.latch)
        holdReg <= slotAddr[DATA_W-1:0];
      if (strb.applyCfg) begin
        {lowerBank, upperBank} <= newPair;
        cfgWriteEn <= holdReg[CFG_WE_BIT];
        romPower   <= holdReg[CFG_PWR_BIT];
      end
    end
  end

  always_comb begin
    upperSel  = slotAddr[OFF_W];
    slotBank  = upperSel ? upperBank : lowerBank;
    memAddr   = {slotBank, slotAddr[OFF_W-1:0]};
    memWrEn   = strb.commit && !(upperSel && (upperBank == ROM_BANK));
    memWrData = holdReg;
    rdData    = memRdData;
  end

endmodule

// File: rtl/ramwr_bank_mapper.sv
module ramwr_bank_mapper
  import rwmap_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int COMMIT_DIST = 5,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 13'h1FF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              cfgWriteEn,
  output logic              romPower,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int OFF_W = ADDR_W - 2;

  ctlStrobes_t strb;

  rwmap_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(DATA_W),
    .COMMIT_DIST(COMMIT_DIST), .CTL_ADDR(CTL_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busAddr(busAddr),
    .wrEnCfg(cfgWriteEn), .strb(strb)
  );

  rwmap_dp #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .slotAddr(busAddr[OFF_W:0]), .strb(strb),
    .memRdData(memRdData), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .rdData(rdData),
    .cfgWriteEn(cfgWriteEn), .romPower(romPower)
  );

endmodule

// File: rtl/rwmap_chk.sv
module rwmap_chk #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 13'h1FF8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              cfgWriteEn,
  input logic              romPower,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn
);

  // R10
  wr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> cfgWriteEn);

  // R9
  no_rom_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr[ADDR_W-1:ADDR_W-2] != 2'd3));

  // R7
  single_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R11
  wr_on_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busEn);

  // R4
  cfg_change_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgWriteEn != $past(cfgWriteEn)) || (romPower != $past(romPower)))
      |-> ($past(busEn) && ($past(busAddr) == CTL_ADDR)));

endmodule

bind ramwr_bank_mapper rwmap_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busAddr(busAddr),
  .cfgWriteEn(cfgWriteEn), .romPower(romPower),
  .memAddr(memAddr), .memWrEn(memWrEn)
);

// File: tb/ramwr_bank_mapper_bench.sv
module ramwr_bank_mapper_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic [12:0] busAddr = '0;
  logic [7:0]  rdData;
  logic        cfgWriteEn;
  logic        romPower;
  logic [12:0] memAddr;
  logic        memWrEn;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData;

  logic [7:0] store [0:8191];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       lastWr;
  logic [7:0] lastWrData;
  logic [7:0] lastRd;
  logic [12:0] lastMemAddr;

  always #2 clk = ~clk;

  ramwr_bank_mapper u_ramwr_bank_mapper (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busAddr(busAddr),
    .rdData(rdData), .cfgWriteEn(cfgWriteEn), .romPower(romPower),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  assign memRdData = store[memAddr];
  always @(posedge clk) if (memWrEn) store[memAddr] <= memWrData;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus access; outputs sampled mid-cycle, before the edge that commits
  task automatic busCycle(input logic [12:0] a);
    @(negedge clk);
    busEn = 1'b1;
    busAddr = a;
    #1;
    lastWr = memWrEn;
    lastWrData = memWrData;
    lastRd = rdData;
    lastMemAddr = memAddr;
  endtask

  task automatic idle();
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic setCfg(input logic [7:0] cfg);
    busCycle({5'b10000, cfg});
    busCycle(13'h1FF8);
    idle();
  endtask

  task automatic testReset();
    #1;
    chk("R1 cfgWriteEn", cfgWriteEn, 0);
    chk("R1 romPower", romPower, 0);
    busCycle(13'h1800);
    chk("R1 upper slot is ROM bank", lastMemAddr, 13'h1800);
    chk("R2 ROM read data", lastRd, 8'hEA);
    busCycle(13'h1400);
    chk("R1 lower slot is bank 2", lastMemAddr, 13'h1400);
    chk("R10 no write while disabled", lastWr, 0);
    idle();
  endtask

  task automatic testCommit();
    setCfg(8'h06); // map 1: lower bank 0, upper ROM, write enabled
    chk("R4 write enable applied", cfgWriteEn, 1);
    busCycle(13'h105A);                // R3 latch 0x5A
    busCycle(13'h1200);
    busCycle(13'h1201);
    busCycle(13'h1201);                // R6 repeats do not count
    busCycle(13'h1201);
    chk("R6 no write on repeated address", lastWr, 0);
    busCycle(13'h1202);
    busCycle(13'h1203);
    chk("R5 no write on fourth access", lastWr, 0);
    busCycle(13'h1123);
    chk("R5 write on fifth access", lastWr, 1);
    chk("R5 write data", lastWrData, 8'h5A);
    chk("R5 write address", lastMemAddr, 13'h0123);
    busCycle(13'h1124);
    chk("R7 no write on sixth access", lastWr, 0);
    busCycle(13'h1123);
    chk("R2 committed byte reads back", lastRd, 8'h5A);
    idle();
  endtask

  task automatic testNoRelatch();
    busCycle(13'h1011);               // latch 0x11
    busCycle(13'h1300);
    busCycle(13'h1301);
    busCycle(13'h1302);
    busCycle(13'h1303);
    busCycle(13'h1044);               // fifth is in trigger page
    chk("R8 trigger access commits", lastWr, 1);
    chk("R8 older byte kept", lastWrData, 8'h11);
    chk("R8 address", lastMemAddr, 13'h0044);
    idle();
  endtask

  task automatic testRomBlock();
    busCycle(13'h1099);
    busCycle(13'h1300);
    busCycle(13'h1301);
    busCycle(13'h1302);
    busCycle(13'h1303);
    busCycle(13'h1900);
    chk("R9 ROM write discarded", lastWr, 0);
    busCycle(13'h1901);
    busCycle(13'h1900);
    chk("R9 ROM unchanged", lastRd, 8'hEA);
    idle();
  endtask

  task automatic testBankSwitch();
    setCfg(8'h1E); // map 7: lower bank 1, upper bank 2
    chk("R4 write enable", cfgWriteEn, 1);
    chk("R4 ROM power", romPower, 0);
    busCycle(13'h1810);
    chk("R4 upper slot bank 2", lastMemAddr, 13'h1010);
    busCycle(13'h1123);
    chk("R4 lower slot bank 1", lastMemAddr, 13'h0923);
    idle();
    setCfg(8'h19); // map 6: lower bank 2, upper bank 1, power on, write off
    chk("R4 write disable", cfgWriteEn, 0);
    chk("R4 ROM power set", romPower, 1);
    busCycle(13'h1800);
    chk("R4 upper slot bank 1", lastMemAddr, 13'h0800);
    idle();
  endtask

  task automatic testWriteDisabled();
    busCycle(13'h1055);
    busCycle(13'h1300);
    busCycle(13'h1301);
    busCycle(13'h1302);
    busCycle(13'h1303);
    busCycle(13'h1400);
    chk("R10 no commit with write disabled", lastWr, 0);
    idle();
    repeat (3) @(negedge clk);
    chk("R11 idle cycles keep config", romPower, 1);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) store[i] = (i >= 6144) ? 8'hEA : 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCommit();
    testNoRelatch();
    testRomBlock();
    testBankSwitch();
    testWriteDisabled();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule